// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block is the bus-facing front end that sits ahead of an instruction execution stage. It keeps a small byte queue of upcoming instruction bytes filled by issuing word-wide fetch cycles on a 16-bit memory bus. Each fetch address is a 20-bit physical address, formed by shifting a 16-bit code segment left by four bits and adding a 16-bit fetch offset. The consumer drains the queue one byte at a time through a valid/ready handshake. While the queue is empty, the consumer simply waits for the next byte to arrive.

The consumer can also ask for one data word to be read or written. That operand request shares the bus with prefetching. A fetch that is already on the bus always finishes first. Whenever the bus is free, a pending operand access wins over a new fetch. A jump request clears the queue at once and moves the fetch offset to the jump target. Any fetch still in flight when the jump arrives is thrown away when its data returns.

The memory side uses a plain request/acknowledge scheme. The request and its address stay asserted until a one-cycle acknowledge, so the memory may insert any number of wait cycles.

Top module: `ifq_front`

## Requirements
- R1: While reset is asserted, `q_valid_o` and `mem_req_o` are 0. The first bus cycle after reset is a fetch (`mem_we_o`=0) at physical address (code_seg << 4) + RESET_OFS, where RESET_OFS defaults to 0.
- R2: Every physical address is ((segment << 4) + offset) truncated to 20 bits. The fetch offset wraps from 0xFFFF to 0x0000.
- R3: Bytes leave the queue in ascending fetch-address order. Exactly one byte is removed on each clock edge where `q_valid_o` and `q_ready_i` are both 1. An unconsumed head byte stays stable.
- R4: A fetch at an even address enqueues `mem_rdata_i[7:0]` and then `mem_rdata_i[15:8]`, and advances the offset by 2. A fetch at an odd address enqueues only `mem_rdata_i[15:8]` and advances the offset by 1, so the next fetch address is even.
- R5: The queue holds at most 6 bytes. A fetch starts only when at least 2 slots are free. When the queue is full and no operand request is pending, `mem_req_o` stays 0.
- R6: Once `mem_req_o` is raised, it stays high with a stable `mem_addr_o` and `mem_we_o` until the cycle in which `mem_ack_i` is 1.
- R7: An operand request that arrives during a fetch cycle waits until that fetch is acknowledged. When the bus is free and both an operand access and a fetch are possible, the operand access goes first.
- R8: An operand cycle drives address (op_seg << 4) + op_ofs, with `mem_we_o` equal to `op_we_i` and, for writes, `mem_wdata_i` equal to `op_wdata_i`. `op_done_o` pulses for one cycle after the acknowledge, with `op_rdata_o` holding the returned word.
- R9: A `jump_i` pulse leaves the queue empty after that clock edge. Fetching resumes at (code_seg << 4) + jump_ofs. Data from a fetch that was on the bus when the jump arrived is not enqueued.
- R10: While the queue is empty, `q_valid_o` stays 0 until the data of a fetch is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_seg_i | input | 16 | Code segment used for fetch addresses |
| jump_i | input | 1 | One-cycle pulse: flush the queue and restart fetching |
| jump_ofs_i | input | 16 | New fetch offset taken on `jump_i` |
| q_valid_o | output | 1 | Head byte of the queue is valid |
| q_byte_o | output | 8 | Head byte of the queue |
| q_ready_i | input | 1 | Consumer takes the head byte |
| op_req_i | input | 1 | Operand access request, held until `op_done_o` |
| op_we_i | input | 1 | Operand access is a write |
| op_seg_i | input | 16 | Operand segment |
| op_ofs_i | input | 16 | Operand offset |
| op_wdata_i | input | 16 | Operand write word |
| op_done_o | output | 1 | Operand access finished (one-cycle pulse) |
| op_rdata_o | output | 16 | Operand read word |
| mem_req_o | output | 1 | Memory cycle request |
| mem_we_o | output | 1 | Memory cycle is a write |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 16 | Memory write word |
| mem_ack_i | input | 1 | Memory cycle done (one-cycle pulse) |
| mem_rdata_i | input | 16 | Memory read word |

## Verification
The queue is first filled with the consumer stalled, which shows that fetching stops at six bytes with two-byte fetches. It is then drained continuously from an even start, which checks ordering and byte-lane selection across refills. Jumps to an odd offset and to an offset near 0xFFFF under segment 0xFFFF separate correct single-byte alignment and correct 16- and 20-bit wrap from a plain incrementing address. An operand read raised during a slow fetch, a write, and a second jump issued while a fetch is still on the bus distinguish finish-fetch-first ordering, operand priority at idle and discard of stale data from their wrong alternatives.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
   typedef enum logic [1:0] {
      BUS_IDLE  = 2'd0,
      BUS_FETCH = 2'd1,
      BUS_OPER  = 2'd2
   } bus_st_t;

   localparam int BYTE_W = 8;
endpackage

// File: rtl/ifq_phys_addr.sv
module ifq_phys_addr #(
   parameter int SEG_W  = 16,
   parameter int OFS_W  = 16,
   parameter int SHIFT  = 4,
   parameter int ADDR_W = 20
) (
   input  logic [SEG_W-1:0]  seg_i,
   input  logic [OFS_W-1:0]  ofs_i,
   output logic [ADDR_W-1:0] phys_o
);
   localparam int SEG_SPAN = SEG_W + SHIFT;

   generate
      if (ADDR_W < 1) begin : g_bad_width
         $error("ifq_phys_addr: ADDR_W must be positive");
      end
      if (SHIFT == 0) begin : g_no_shift
         assign phys_o = ADDR_W'(seg_i) + ADDR_W'(ofs_i);
      end else begin : g_shift
         logic [SEG_SPAN-1:0] seg_base;
         assign seg_base = {seg_i, {SHIFT{1'b0}}};
         assign phys_o   = ADDR_W'(seg_base) + ADDR_W'(ofs_i);
      end
   endgenerate
endmodule

// File: rtl/ifq_byte_queue.sv
module ifq_byte_queue #(
   parameter int DEPTH = 6,
   parameter int LANES = 2,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int LW    = $clog2(LANES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush_i,
   input  logic [LW-1:0]      push_n_i,
   input  logic [LANES*8-1:0] push_data_i,
   input  logic               pop_i,
   output logic [7:0]         head_o,
   output logic               valid_o,
   output logic [CNT_W-1:0]   count_o
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int SUM_W = $clog2(2 * DEPTH + 1) + 1;

   generate
      if (DEPTH < LANES) begin : g_bad_depth
         $error("ifq_byte_queue: DEPTH must hold one full bus word");
      end
   endgenerate

   logic [7:0]       slot_q [DEPTH];
   logic [IDX_W-1:0] rd_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pop_eff;

   function automatic logic [IDX_W-1:0] wrap_idx(input logic [SUM_W-1:0] v);
      logic [SUM_W-1:0] r;
      r = v;
      if (r >= SUM_W'(DEPTH)) r = r - SUM_W'(DEPTH);
      if (r >= SUM_W'(DEPTH)) r = r - SUM_W'(DEPTH);
      return IDX_W'(r);
   endfunction

   assign valid_o = (cnt_q != '0);
   assign head_o  = slot_q[rd_q];
   assign count_o = cnt_q;
   assign pop_eff = pop_i && valid_o && !flush_i;

   always_ff @(posedge clk) begin
      if (!flush_i) begin
         for (int k = 0; k < LANES; k++) begin
            if (32'(push_n_i) > k) begin
               slot_q[wrap_idx(SUM_W'(rd_q) + SUM_W'(cnt_q) + SUM_W'(k))] <= push_data_i[k*8 +: 8];
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_q  <= '0;
         cnt_q <= '0;
      end else if (flush_i) begin
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (pop_eff) rd_q <= wrap_idx(SUM_W'(rd_q) + SUM_W'(1));
         cnt_q <= cnt_q + CNT_W'(push_n_i) - CNT_W'(pop_eff);
      end
   end

   // R5: a push never exceeds the free room
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      !flush_i |-> (32'(push_n_i) + 32'(cnt_q) - 32'(pop_eff) <= DEPTH));

   // R9: a flush leaves the queue empty
   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> !valid_o);

   // R3: an unconsumed head byte holds
   a_r3_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !pop_i && !flush_i) |=> (valid_o && $stable(head_o)));
endmodule

// File: rtl/ifq_bus_seq.sv
module ifq_bus_seq
   import ifq_pkg::*;
#(
   parameter int SEG_W     = 16,
   parameter int OFS_W     = 16,
   parameter int SHIFT     = 4,
   parameter int ADDR_W    = 20,
   parameter int BUS_W     = 16,
   parameter int DEPTH     = 6,
   parameter logic [OFS_W-1:0] RESET_OFS = '0,
   localparam int LANES    = BUS_W / 8,
   localparam int CNT_W    = $clog2(DEPTH + 1),
   localparam int LW       = $clog2(LANES + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SEG_W-1:0]   code_seg_i,
   input  logic               jump_i,
   input  logic [OFS_W-1:0]   jump_ofs_i,
   input  logic               op_req_i,
   input  logic               op_we_i,
   input  logic [SEG_W-1:0]   op_seg_i,
   input  logic [OFS_W-1:0]   op_ofs_i,
   input  logic [BUS_W-1:0]   op_wdata_i,
   output logic               op_done_o,
   output logic [BUS_W-1:0]   op_rdata_o,
   input  logic [CNT_W-1:0]   q_free_i,
   output logic [LW-1:0]      push_n_o,
   output logic [BUS_W-1:0]   push_data_o,
   output logic               mem_req_o,
   output logic               mem_we_o,
   output logic [ADDR_W-1:0]  mem_addr_o,
   output logic [BUS_W-1:0]   mem_wdata_o,
   input  logic               mem_ack_i,
   input  logic [BUS_W-1:0]   mem_rdata_i
);
   localparam int MIN_FREE = LANES;

   generate
      if (BUS_W != 16) begin : g_bad_bus
         $error("ifq_bus_seq: the byte steering expects a 16-bit bus");
      end
   endgenerate

   bus_st_t          st_q;
   logic [OFS_W-1:0] fetch_ofs_q;
   logic             discard_q;
   logic [ADDR_W-1:0] fetch_pa, op_pa;
   logic             start_fetch, accept, odd_fetch;

   ifq_phys_addr #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W))
      u_fetch_pa (.seg_i(code_seg_i), .ofs_i(fetch_ofs_q), .phys_o(fetch_pa));

   ifq_phys_addr #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W))
      u_op_pa (.seg_i(op_seg_i), .ofs_i(op_ofs_i), .phys_o(op_pa));

   always_comb begin
      start_fetch = (st_q == BUS_IDLE) && !op_req_i && !jump_i &&
                    (q_free_i >= CNT_W'(MIN_FREE));
      odd_fetch   = mem_addr_o[0];
      accept      = (st_q == BUS_FETCH) && mem_ack_i && !discard_q && !jump_i;
      push_n_o    = '0;
      push_data_o = mem_rdata_i;
      if (accept) begin
         if (odd_fetch) begin
            push_n_o    = LW'(1);
            push_data_o = {8'h00, mem_rdata_i[15:8]};
         end else begin
            push_n_o    = LW'(2);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= BUS_IDLE;
         fetch_ofs_q <= RESET_OFS;
         discard_q   <= 1'b0;
         mem_req_o   <= 1'b0;
         mem_we_o    <= 1'b0;
         mem_addr_o  <= '0;
         mem_wdata_o <= '0;
         op_done_o   <= 1'b0;
         op_rdata_o  <= '0;
      end else begin
         op_done_o <= 1'b0;
         if (jump_i) begin
            fetch_ofs_q <= jump_ofs_i;
            if (st_q == BUS_FETCH && !mem_ack_i) discard_q <= 1'b1;
         end
         case (st_q)
            BUS_IDLE: begin
               if (op_req_i) begin
                  mem_req_o   <= 1'b1;
                  mem_we_o    <= op_we_i;
                  mem_addr_o  <= op_pa;
                  mem_wdata_o <= op_wdata_i;
                  st_q        <= BUS_OPER;
               end else if (start_fetch) begin
                  mem_req_o  <= 1'b1;
                  mem_we_o   <= 1'b0;
                  mem_addr_o <= fetch_pa;
                  st_q       <= BUS_FETCH;
               end
            end
            BUS_FETCH: begin
               if (mem_ack_i) begin
                  mem_req_o <= 1'b0;
                  discard_q <= 1'b0;
                  st_q      <= BUS_IDLE;
                  if (accept) begin
                     fetch_ofs_q <= fetch_ofs_q + (odd_fetch ? OFS_W'(1) : OFS_W'(2));
                  end
               end
            end
            BUS_OPER: begin
               if (mem_ack_i) begin
                  mem_req_o  <= 1'b0;
                  mem_we_o   <= 1'b0;
                  op_done_o  <= 1'b1;
                  op_rdata_o <= mem_rdata_i;
                  st_q       <= BUS_IDLE;
               end
            end
            default: st_q <= BUS_IDLE;
         endcase
      end
   end

   // R6: request, address and direction hold until acknowledged
   a_r6_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

   // R5: full queue and no operand keeps the bus quiet
   a_r5_idle_full: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BUS_IDLE && q_free_i == '0 && !op_req_i) |=> !mem_req_o);

   // R7: an unfinished fetch stays on the bus as a read
   a_r7_fetch_first: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == BUS_FETCH && !mem_ack_i) |=> (mem_req_o && !mem_we_o));

   // R8: completion is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      op_done_o |=> !op_done_o);
endmodule

// File: rtl/ifq_front.sv
module ifq_front #(
   parameter int SEG_W  = 16,
   parameter int OFS_W  = 16,
   parameter int SHIFT  = 4,
   parameter int ADDR_W = 20,
   parameter int BUS_W  = 16,
   parameter int DEPTH  = 6,
   parameter logic [OFS_W-1:0] RESET_OFS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEG_W-1:0]  code_seg_i,
   input  logic              jump_i,
   input  logic [OFS_W-1:0]  jump_ofs_i,
   output logic              q_valid_o,
   output logic [7:0]        q_byte_o,
   input  logic              q_ready_i,
   input  logic              op_req_i,
   input  logic              op_we_i,
   input  logic [SEG_W-1:0]  op_seg_i,
   input  logic [OFS_W-1:0]  op_ofs_i,
   input  logic [BUS_W-1:0]  op_wdata_i,
   output logic              op_done_o,
   output logic [BUS_W-1:0]  op_rdata_o,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [BUS_W-1:0]  mem_wdata_o,
   input  logic              mem_ack_i,
   input  logic [BUS_W-1:0]  mem_rdata_i
);
   localparam int LANES = BUS_W / 8;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int LW    = $clog2(LANES + 1);

   logic [CNT_W-1:0] q_count, q_free;
   logic [LW-1:0]    push_n;
   logic [BUS_W-1:0] push_data;

   assign q_free = CNT_W'(DEPTH) - q_count;

   ifq_bus_seq #(
      .SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W),
      .BUS_W(BUS_W), .DEPTH(DEPTH), .RESET_OFS(RESET_OFS)
   ) u_bus (
      .clk(clk), .rst_n(rst_n),
      .code_seg_i(code_seg_i), .jump_i(jump_i), .jump_ofs_i(jump_ofs_i),
      .op_req_i(op_req_i), .op_we_i(op_we_i), .op_seg_i(op_seg_i),
      .op_ofs_i(op_ofs_i), .op_wdata_i(op_wdata_i),
      .op_done_o(op_done_o), .op_rdata_o(op_rdata_o),
      .q_free_i(q_free), .push_n_o(push_n), .push_data_o(push_data),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i)
   );

   ifq_byte_queue #(.DEPTH(DEPTH), .LANES(LANES)) u_queue (
      .clk(clk), .rst_n(rst_n), .flush_i(jump_i),
      .push_n_i(push_n), .push_data_i(push_data), .pop_i(q_ready_i),
      .head_o(q_byte_o), .valid_o(q_valid_o), .count_o(q_count)
   );

   // R1: nothing is offered or requested during reset
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!q_valid_o && !mem_req_o) or rst_n);
endmodule

// File: tb/sim_ifq_front.sv
module sim_ifq_front;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [15:0] code_seg = 16'h1000;
   logic        jump = 1'b0;
   logic [15:0] jump_ofs = 16'h0;
   logic        q_valid, q_ready = 1'b0;
   logic [7:0]  q_byte;
   logic        op_req = 1'b0, op_we = 1'b0, op_done;
   logic [15:0] op_seg = 16'h0, op_ofs = 16'h0, op_wdata = 16'h0, op_rdata;
   logic        mem_req, mem_we, mem_ack;
   logic [19:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata;

   ifq_front u0 (
      .clk(clk), .rst_n(rst_n), .code_seg_i(code_seg), .jump_i(jump), .jump_ofs_i(jump_ofs),
      .q_valid_o(q_valid), .q_byte_o(q_byte), .q_ready_i(q_ready),
      .op_req_i(op_req), .op_we_i(op_we), .op_seg_i(op_seg), .op_ofs_i(op_ofs),
      .op_wdata_i(op_wdata), .op_done_o(op_done), .op_rdata_o(op_rdata),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
   );

   int checks = 0;
   int fails  = 0;

   function automatic logic [7:0] byte_at(input logic [19:0] a);
      return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h3C;
   endfunction

   function automatic logic [15:0] word_at(input logic [19:0] a);
      return {byte_at({a[19:1], 1'b1}), byte_at({a[19:1], 1'b0})};
   endfunction

   function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
      logic [19:0] p;
      p = {s, 4'h0} + {4'h0, o};
      return p;
   endfunction

   // memory model with a programmable number of wait cycles
   int          mem_wait = 2;
   int          wcnt;
   logic [19:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
         wcnt      <= 0;
      end else if (mem_ack) begin
         mem_ack <= 1'b0;
         wcnt    <= 0;
      end else if (mem_req) begin
         if (wcnt >= mem_wait) begin
            mem_ack   <= 1'b1;
            mem_rdata <= word_at(mem_addr);
            if (mem_we) begin
               wr_addr <= mem_addr;
               wr_data <= mem_wdata;
            end
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   // bus cycle log and stability monitor
   logic [19:0] log_addr [256];
   logic        log_we [256];
   int          log_n;
   logic        req_d;
   logic [19:0] addr_d;
   int          stab_err;
   always @(posedge clk) begin
      if (!rst_n) begin
         log_n    <= 0;
         req_d    <= 1'b0;
         addr_d   <= '0;
         stab_err <= 0;
      end else begin
         req_d  <= mem_req;
         addr_d <= mem_addr;
         if (mem_req && !req_d) begin
            log_addr[log_n[7:0]] <= mem_addr;
            log_we[log_n[7:0]]   <= mem_we;
            log_n <= log_n + 1;
         end
         if (mem_req && req_d && !mem_ack && mem_addr != addr_d) stab_err <= stab_err + 1;
      end
   end

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_jump(input logic [15:0] s, input logic [15:0] o);
      @(negedge clk);
      code_seg = s;
      jump_ofs = o;
      jump     = 1'b1;
      @(negedge clk);
      jump = 1'b0;
   endtask

   task automatic wait_req();
      int guard = 0;
      while (!mem_req && guard < 500) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic wait_done();
      int guard = 0;
      while (!op_done && guard < 500) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic pop_check(input logic [15:0] s, input logic [15:0] o, input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         logic [15:0] ofs = o + 16'(i);
         logic [19:0] pa  = phys(s, ofs);
         int guard = 0;
         while (!q_valid && guard < 500) begin
            @(negedge clk);
            guard++;
         end
         check(q_valid && q_byte == byte_at(pa), tag, int'(q_byte), int'(byte_at(pa)));
         q_ready = 1'b1;
         @(negedge clk);
         q_ready = 1'b0;
      end
   endtask

   task automatic t_reset();
      int bad = 0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (q_valid || mem_req) bad++;
      end
      check(bad == 0, "R1 quiet in reset", bad, 0);
      rst_n = 1'b1;
      wait_req();
      check(mem_addr == 20'h10000 && !mem_we, "R1/R2 first fetch address", int'(mem_addr), 32'h10000);
   endtask

   task automatic t_fill();
      repeat (60) @(negedge clk);
      check(log_n == 3, "R5 three fetches fill the queue", log_n, 3);
      check(q_valid && !mem_req, "R5 bus idle when full", int'(mem_req), 0);
   endtask

   task automatic t_drain();
      pop_check(16'h1000, 16'h0000, 20, "R3/R4 stream order");
   endtask

   task automatic t_wrap();
      do_jump(16'hFFFF, 16'hFFFC);
      check(!q_valid, "R9 queue empty after jump", int'(q_valid), 0);
      pop_check(16'hFFFF, 16'hFFFC, 8, "R2 offset and address wrap");
   endtask

   task automatic t_op_read();
      int base;
      mem_wait = 4;
      repeat (60) @(negedge clk);
      base = log_n;
      do_jump(16'h2000, 16'h0100);
      wait_req();
      op_seg = 16'h3000;
      op_ofs = 16'h0042;
      op_we  = 1'b0;
      op_req = 1'b1;
      @(negedge clk);
      check(mem_req && !mem_we && mem_addr == 20'h20100, "R7 fetch kept on bus", int'(mem_addr), 32'h20100);
      wait_done();
      check(op_done && op_rdata == word_at(20'h30042), "R8 operand read data", int'(op_rdata), int'(word_at(20'h30042)));
      op_req = 1'b0;
      check(log_addr[base[7:0]] == 20'h20100 && !log_we[base[7:0]], "R7 fetch completed first",
            int'(log_addr[base[7:0]]), 32'h20100);
      check(log_addr[8'(base + 1)] == 20'h30042, "R7 operand before next fetch",
            int'(log_addr[8'(base + 1)]), 32'h30042);
      pop_check(16'h2000, 16'h0100, 4, "R3 after operand");
   endtask

   task automatic t_op_write();
      repeat (40) @(negedge clk);
      op_seg   = 16'h3000;
      op_ofs   = 16'h0080;
      op_we    = 1'b1;
      op_wdata = 16'hBEEF;
      op_req   = 1'b1;
      wait_done();
      op_req = 1'b0;
      op_we  = 1'b0;
      @(negedge clk);
      check(wr_addr == 20'h30080, "R8 write address", int'(wr_addr), 32'h30080);
      check(wr_data == 16'hBEEF, "R8 write data", int'(wr_data), 32'hBEEF);
   endtask

   task automatic t_discard();
      int base;
      int bad = 0;
      mem_wait = 6;
      repeat (60) @(negedge clk);
      do_jump(16'h2000, 16'h0200);
      wait_req();
      repeat (2) @(negedge clk);
      base = log_n;
      do_jump(16'h2000, 16'h0301);
      for (int i = 0; i < 10; i++) begin
         if (q_valid) bad++;
         @(negedge clk);
      end
      check(bad == 0, "R10/R9 stale fetch discarded, consumer waits", bad, 0);
      pop_check(16'h2000, 16'h0301, 5, "R4 odd start");
      check(log_addr[base[7:0]] == 20'h20301, "R9 restart at target", int'(log_addr[base[7:0]]), 32'h20301);
      check(log_addr[8'(base + 1)] == 20'h20302, "R4 aligned after odd fetch",
            int'(log_addr[8'(base + 1)]), 32'h20302);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired (all requirements): actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      t_reset();
      t_fill();
      t_drain();
      t_wrap();
      t_op_read();
      t_op_write();
      t_discard();
      check(stab_err == 0, "R6 request held stable", stab_err, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule